// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host side of a three-channel interval timer. A host reaches it through a 2-bit address. Addresses 0 to 2 are the data ports of channels 0 to 2. Address 3 is a control port that accepts writes only. The counter channels sit outside this block. Each one supplies its live 16-bit count and its output level. In return each channel receives a load strobe, a 16-bit load value, its operating mode and its BCD flag. The BCD flag is only stored and reported; no decimal arithmetic is done here.

Control writes do one of three things: program a channel's access and operating mode, freeze a channel's count, or, as a read-back command, freeze counts and/or status for several channels at once. Frozen values stay in place until the host reads them. A pending status is read before a pending count, and a pending count is read before the live counter. A channel in 16-bit access mode moves its bytes low first, then high. Reads and writes each have their own byte toggle.

Read data is combinational from the current state while `rd_en` is high. The state change caused by a read (popping a latch, flipping the read toggle) takes effect at the clock edge that ends the access.

Top module: `timer_host_if`

## Requirements
- R1: Reset holds every load strobe high and drives load value 0, mode 0 and BCD 0 on every channel. In the first cycle after reset the strobes are still high. After reset no latch is pending, both toggles select the low byte, and the access mode is low-then-high.
- R2: A write to address 3 whose bits 7:6 hold a channel number 0..2 and whose bits 5:4 are non-zero sets that channel's access mode (bits 5:4), its mode (bits 3:1) and its BCD flag (bit 0). `mode_o`/`bcd_o` change in the cycle after the write and at no other time.
- R3: In access mode 1 (low byte only) a data write loads `{8'h00, byte}`. In access mode 2 (high byte only) it loads `{byte, 8'h00}`. The load strobe of that one channel is high for exactly the cycle after the write.
- R4: In access mode 3 (low then high) the first data write only holds the byte and gives no strobe. The second write loads `{second, first}` and strobes. The load value of a channel never changes without its strobe.
- R5: Programming a channel's access mode returns both its read toggle and its write toggle to the low byte.
- R6: A control write with bits 5:4 = 0 freezes the named channel's live count, but only if no count is already pending, and it leaves that channel's mode and access unchanged.
- R7: A pending count is read according to the access mode. Mode 1 returns the low byte and mode 2 returns the high byte, each in one read. Mode 3 returns the low byte and then the high byte in two reads. After that, reads return the live count again.
- R8: A control write with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 freezes the counts of all selected channels, and bit 4 = 0 freezes their status.
- R9: A status byte is `{out, 1'b0, access[1:0], mode[2:0], bcd}`. A status that is already pending is not replaced. A pending status is read first and is cleared by that read.
- R10: With nothing pending, mode 1 reads the live low byte and mode 2 the live high byte. Mode 3 alternates between the low byte and the high byte of the live count on successive reads.
- R11: A read at address 3 returns 0 and changes no channel's state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| rd_en | input | 1 | Host read strobe, one cycle per byte |
| addr | input | 2 | 0..2 data port of a channel, 3 control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while rd_en is high |
| live_cnt_i | input | 48 | Live count of each channel, channel i at bits 16i+15:16i |
| out_lvl_i | input | 3 | Output level of each channel |
| load_stb_o | output | 3 | One-cycle load pulse per channel |
| load_val_o | output | 48 | Count to load, channel i at bits 16i+15:16i |
| mode_o | output | 9 | Operating mode, channel i at bits 3i+2:3i |
| bcd_o | output | 3 | Stored BCD flag per channel |

## Verification
The bench goes after the ordering of the read path: status before count, count before live, and the two-step word latch. A design that got this wrong would return live bytes while a frozen value is still waiting, or would lose the high byte of a frozen word. It repeats latch and read-back commands while a latch is pending. A design that overwrote the pending value would hand back the later count or status. It also programs the access mode between the two bytes of a word. A design that kept the old toggles would load a half-old count or read the high byte first. Reads at the control port are mixed into the random traffic, so a decode that let them pop a latch or flip a toggle would show up as wrong bytes later on.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;

    localparam int CH_NUM  = 3;
    localparam int CNT_W   = 16;
    localparam int MODE_W  = 3;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'd0,
        ACC_LO     = 2'd1,
        ACC_HI     = 2'd2,
        ACC_WORD   = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } chan_cfg_t;

    typedef struct packed {
        logic      set_cfg;
        logic      frz_cnt;
        logic      frz_sts;
        chan_cfg_t cfg;
    } chan_cmd_t;

    function automatic logic [7:0] make_status(input logic out_lvl, input chan_cfg_t cfg);
        return {out_lvl, 1'b0, cfg};
    endfunction

    function automatic logic [7:0] pick_byte(input logic [CNT_W-1:0] val, input logic hi);
        return hi ? val[15:8] : val[7:0];
    endfunction

endpackage

// File: rtl/thi_cmd_decode.sv
module thi_cmd_decode
    import timer_host_pkg::*;
#(
    parameter int NCH = CH_NUM
) (
    input  logic      ctl_wr,
    input  logic [7:0] wbyte,
    output chan_cmd_t cmd_o [NCH]
);

    logic is_rdback;
    logic is_freeze;

    assign is_rdback = (wbyte[7:6] == 2'd3);
    assign is_freeze = (wbyte[5:4] == 2'd0);

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        logic named;
        logic picked;
        assign named  = !is_rdback && (wbyte[7:6] == gi[1:0]);
        assign picked = is_rdback && wbyte[gi+1];
        always_comb begin
            cmd_o[gi].set_cfg = ctl_wr && named && !is_freeze;
            cmd_o[gi].frz_cnt = ctl_wr && ((named && is_freeze) || (picked && !wbyte[5]));
            cmd_o[gi].frz_sts = ctl_wr && picked && !wbyte[4];
            cmd_o[gi].cfg     = chan_cfg_t'(wbyte[5:0]);
        end
    end

endmodule

// File: rtl/thi_channel.sv
module thi_channel
    import timer_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chan_cmd_t        cmd,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [7:0]       wbyte,
    input  logic [CNT_W-1:0] live,
    input  logic             out_lvl,
    output logic [7:0]       rbyte,
    output logic             load_stb,
    output logic [CNT_W-1:0] load_val,
    output chan_cfg_t        cfg
);

    logic             wr_hi;
    logic             rd_hi;
    logic [7:0]       held_lo;
    acc_e             frz_kind;
    logic [CNT_W-1:0] frz_val;
    logic             sts_pend;
    logic [7:0]       sts_val;

    always_comb begin
        if (sts_pend) begin
            rbyte = sts_val;
        end else if (frz_kind != ACC_FREEZE) begin
            rbyte = pick_byte(frz_val, frz_kind == ACC_HI);
        end else begin
            unique case (cfg.acc)
                ACC_LO:   rbyte = pick_byte(live, 1'b0);
                ACC_HI:   rbyte = pick_byte(live, 1'b1);
                ACC_WORD: rbyte = pick_byte(live, rd_hi);
                default:  rbyte = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '{acc: ACC_WORD, mode: '0, bcd: 1'b0};
            wr_hi    <= 1'b0;
            rd_hi    <= 1'b0;
            held_lo  <= '0;
            frz_kind <= ACC_FREEZE;
            frz_val  <= '0;
            sts_pend <= 1'b0;
            sts_val  <= '0;
            load_stb <= 1'b1;
            load_val <= '0;
        end else begin
            load_stb <= 1'b0;
            if (cmd.set_cfg) begin
                cfg   <= cmd.cfg;
                wr_hi <= 1'b0;
                rd_hi <= 1'b0;
            end
            if (cmd.frz_cnt && frz_kind == ACC_FREEZE) begin
                frz_val  <= live;
                frz_kind <= cfg.acc;
            end
            if (cmd.frz_sts && !sts_pend) begin
                sts_val  <= make_status(out_lvl, cfg);
                sts_pend <= 1'b1;
            end
            if (dat_wr) begin
                unique case (cfg.acc)
                    ACC_LO: begin
                        load_val <= {8'h00, wbyte};
                        load_stb <= 1'b1;
                    end
                    ACC_HI: begin
                        load_val <= {wbyte, 8'h00};
                        load_stb <= 1'b1;
                    end
                    ACC_WORD: begin
                        if (!wr_hi) begin
                            held_lo <= wbyte;
                            wr_hi   <= 1'b1;
                        end else begin
                            load_val <= {wbyte, held_lo};
                            load_stb <= 1'b1;
                            wr_hi    <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (dat_rd) begin
                if (sts_pend) begin
                    sts_pend <= 1'b0;
                end else if (frz_kind != ACC_FREEZE) begin
                    frz_kind <= (frz_kind == ACC_WORD) ? ACC_HI : ACC_FREEZE;
                end else if (cfg.acc == ACC_WORD) begin
                    rd_hi <= !rd_hi;
                end
            end
        end
    end

endmodule

// File: rtl/timer_host_if.sv
module timer_host_if
    import timer_host_pkg::*;
#(
    parameter int NCH = CH_NUM
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [1:0]            addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    input  logic [NCH*CNT_W-1:0]  live_cnt_i,
    input  logic [NCH-1:0]        out_lvl_i,
    output logic [NCH-1:0]        load_stb_o,
    output logic [NCH*CNT_W-1:0]  load_val_o,
    output logic [NCH*MODE_W-1:0] mode_o,
    output logic [NCH-1:0]        bcd_o
);

    localparam logic [1:0] CTL_ADDR = 2'd3;

    chan_cmd_t  cmd   [NCH];
    logic [7:0] rbyte [NCH];

    thi_cmd_decode #(.NCH(NCH)) u_dec (
        .ctl_wr (wr_en && (addr == CTL_ADDR)),
        .wbyte  (wdata),
        .cmd_o  (cmd)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        chan_cfg_t cfg;
        thi_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd[gi]),
            .dat_wr   (wr_en && (addr == gi[1:0])),
            .dat_rd   (rd_en && (addr == gi[1:0])),
            .wbyte    (wdata),
            .live     (live_cnt_i[gi*CNT_W +: CNT_W]),
            .out_lvl  (out_lvl_i[gi]),
            .rbyte    (rbyte[gi]),
            .load_stb (load_stb_o[gi]),
            .load_val (load_val_o[gi*CNT_W +: CNT_W]),
            .cfg      (cfg)
        );
        assign mode_o[gi*MODE_W +: MODE_W] = cfg.mode;
        assign bcd_o[gi]                   = cfg.bcd;
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NCH; i++) begin
            if (rd_en && addr == i[1:0]) begin
                rdata = rbyte[i];
            end
        end
    end

endmodule

// File: rtl/timer_host_chk.sv
module timer_host_chk
    import timer_host_pkg::*;
#(
    parameter int NCH = CH_NUM
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [1:0]            addr,
    input logic [7:0]            rdata,
    input logic [NCH-1:0]        load_stb_o,
    input logic [NCH*CNT_W-1:0]  load_val_o,
    input logic [NCH*MODE_W-1:0] mode_o,
    input logic [NCH-1:0]        bcd_o
);

    AST_RESET_LOADS_ALL: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (load_stb_o == {NCH{1'b1}})); // R1

    AST_CFG_ONLY_BY_CTL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(wr_en) && $past(addr) == 2'd3)) |-> ($stable(mode_o) && $stable(bcd_o))); // R2

    AST_STB_FROM_DATA_WR: assert property (@(posedge clk) disable iff (rst)
        ((load_stb_o != '0) && !$past(rst)) |-> ($past(wr_en) && $past(addr) != 2'd3)); // R3

    AST_STB_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $onehot0(load_stb_o)); // R3

    AST_VAL_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
        (load_stb_o == '0) |-> $stable(load_val_o)); // R4

    AST_CTL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd3) |-> (rdata == 8'h00)); // R11

endmodule

bind timer_host_if timer_host_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .rdata      (rdata),
    .load_stb_o (load_stb_o),
    .load_val_o (load_val_o),
    .mode_o     (mode_o),
    .bcd_o      (bcd_o)
);

// File: tb/tb_timer_host_if.sv
`timescale 1ns/1ps
module tb_timer_host_if;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'h00;
    logic [47:0] live = '0;
    logic [2:0]  outl = '0;
    logic [7:0]  rdata;
    logic [2:0]  stb;
    logic [47:0] lval;
    logic [8:0]  mode;
    logic [2:0]  bcd;

    timer_host_if dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_cnt_i(live), .out_lvl_i(outl),
        .load_stb_o(stb), .load_val_o(lval), .mode_o(mode), .bcd_o(bcd)
    );

    always #4 clk = ~clk;

    int nvec = 0;
    int nbad = 0;

    // reference state computed from the requirements
    logic [1:0]  m_acc [3];
    logic [2:0]  m_mode[3];
    logic        m_bcd [3];
    logic        m_wt  [3];
    logic        m_rt  [3];
    logic [7:0]  m_hold[3];
    logic [1:0]  m_cl  [3];
    logic [15:0] m_cv  [3];
    logic        m_sp  [3];
    logic [7:0]  m_sv  [3];
    logic [15:0] e_lv  [3];
    logic [2:0]  e_stb;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] live_of(int i);
        return live[i*16 +: 16];
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < 3; i++) begin
            m_acc[i] = 2'd3; m_mode[i] = '0; m_bcd[i] = 1'b0;
            m_wt[i] = 1'b0; m_rt[i] = 1'b0; m_hold[i] = '0;
            m_cl[i] = '0; m_cv[i] = '0; m_sp[i] = 1'b0; m_sv[i] = '0;
            e_lv[i] = '0;
        end
        e_stb = 3'b111;
    endtask

    task automatic mdl_freeze(int i);    // R6 / R8
        if (m_cl[i] == 2'd0) begin
            m_cv[i] = live_of(i);
            m_cl[i] = m_acc[i];
        end
    endtask

    task automatic mdl_status(int i);    // R9
        if (!m_sp[i]) begin
            m_sv[i] = {outl[i], 1'b0, m_acc[i], m_mode[i], m_bcd[i]};
            m_sp[i] = 1'b1;
        end
    endtask

    task automatic check_outputs(string tag);
        chk(tag, {13'd0, stb}, {13'd0, e_stb});
        for (int i = 0; i < 3; i++) begin
            chk(tag, lval[i*16 +: 16], e_lv[i]);
            chk(tag, {13'd0, mode[i*3 +: 3]}, {13'd0, m_mode[i]});
            chk(tag, {15'd0, bcd[i]}, {15'd0, m_bcd[i]});
        end
    endtask

    task automatic do_write(logic [1:0] a, logic [7:0] d, string tag);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        e_stb = 3'b000;
        if (a == 2'd3) begin
            if (d[7:6] == 2'd3) begin
                for (int i = 0; i < 3; i++) begin
                    if (d[i+1]) begin
                        if (!d[5]) mdl_freeze(i);
                        if (!d[4]) mdl_status(i);
                    end
                end
            end else if (d[5:4] == 2'd0) begin
                mdl_freeze(int'(d[7:6]));
            end else begin
                m_acc[d[7:6]] = d[5:4]; m_mode[d[7:6]] = d[3:1]; m_bcd[d[7:6]] = d[0];
                m_wt[d[7:6]] = 1'b0; m_rt[d[7:6]] = 1'b0;
            end
        end else begin
            case (m_acc[a])
                2'd1: begin e_lv[a] = {8'h00, d}; e_stb[a] = 1'b1; end
                2'd2: begin e_lv[a] = {d, 8'h00}; e_stb[a] = 1'b1; end
                2'd3: begin
                    if (!m_wt[a]) begin
                        m_hold[a] = d; m_wt[a] = 1'b1;
                    end else begin
                        e_lv[a] = {d, m_hold[a]}; e_stb[a] = 1'b1; m_wt[a] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;
        check_outputs(tag);
    endtask

    task automatic do_read(logic [1:0] a, string tag);
        logic [7:0] exp;
        addr = a; rd_en = 1'b1;
        #1;
        exp = 8'h00;
        if (a != 2'd3) begin
            if (m_sp[a]) begin
                exp = m_sv[a]; m_sp[a] = 1'b0;
            end else if (m_cl[a] != 2'd0) begin
                case (m_cl[a])
                    2'd1:    begin exp = m_cv[a][7:0];  m_cl[a] = 2'd0; end
                    2'd2:    begin exp = m_cv[a][15:8]; m_cl[a] = 2'd0; end
                    default: begin exp = m_cv[a][7:0];  m_cl[a] = 2'd2; end
                endcase
            end else begin
                case (m_acc[a])
                    2'd1:    exp = live_of(a)[7:0];
                    2'd2:    exp = live_of(a)[15:8];
                    default: begin
                        exp = m_rt[a] ? live_of(a)[15:8] : live_of(a)[7:0];
                        m_rt[a] = !m_rt[a];
                    end
                endcase
            end
        end
        chk(tag, {8'h00, rdata}, {8'h00, exp});
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        e_stb = 3'b000;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h0BAD5EED));
        live = {16'h5A5A, 16'hC3C3, 16'h1234};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mdl_reset();
        check_outputs("R1");                  // R1 strobes high, values zero
        do_read(2'd0, "R1");                  // R1 word access, low byte first
        do_read(2'd0, "R1");

        do_write(2'd3, 8'b01_01_010_1, "R2"); // ch1 low only, mode 2, bcd
        do_write(2'd1, 8'hA5, "R3");          // R3 -> 00A5
        do_write(2'd3, 8'b10_10_011_0, "R2"); // ch2 high only, mode 3
        do_write(2'd2, 8'h3C, "R3");          // R3 -> 3C00
        do_write(2'd0, 8'h34, "R4");          // R4 held, no strobe
        do_write(2'd0, 8'h12, "R4");          // R4 -> 1234

        do_write(2'd0, 8'h77, "R5");          // R5 half word pending
        do_read(2'd0, "R5");                  // read toggle now high
        do_write(2'd3, 8'b00_11_100_0, "R5"); // reprogram resets toggles
        do_read(2'd0, "R5");                  // low byte again
        do_write(2'd0, 8'h11, "R5");
        do_write(2'd0, 8'h22, "R5");          // -> 2211

        do_read(2'd0, "R10");                 // toggle back to low
        live[15:0] = 16'hABCD;
        do_write(2'd3, 8'b00_00_111_1, "R6"); // freeze ch0, mode untouched
        live[15:0] = 16'h1111;
        do_write(2'd3, 8'b00_00_000_0, "R6"); // ignored, pending
        do_read(2'd0, "R7");                  // CD
        do_read(2'd0, "R7");                  // AB
        do_read(2'd0, "R7");                  // live again

        do_read(2'd1, "R10");                 // low-only live
        do_read(2'd2, "R10");                 // high-only live
        live = {16'h9988, 16'h7766, 16'h5544};
        outl = 3'b101;
        do_write(2'd3, 8'b11_01_111_0, "R8"); // freeze counts of all
        do_write(2'd3, 8'b11_10_110_0, "R8"); // status of ch1, ch2
        outl = 3'b010;
        do_write(2'd3, 8'b11_10_100_0, "R9"); // ch2 status pending, kept
        do_read(2'd2, "R9");                  // status first
        do_read(2'd2, "R8");                  // then frozen count
        do_read(2'd1, "R9");
        do_read(2'd1, "R8");
        do_read(2'd0, "R8");
        do_read(2'd0, "R8");
        do_write(2'd3, 8'b11_00_001_0, "R8"); // ch0 count and status
        do_read(2'd3, "R11");                 // no effect
        do_read(2'd0, "R9");
        do_read(2'd0, "R7");
        do_read(2'd0, "R7");

        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [1:0] ch;
            live = {$urandom, $urandom};
            outl = 3'($urandom);
            op = int'($urandom % 10);
            ch = 2'($urandom % 3);
            case (op)
                0: do_write(2'd3, {ch, 2'($urandom % 3 + 1), 3'($urandom), 1'($urandom)}, "R2");
                1: do_write(2'd3, {ch, 2'b00, 4'($urandom)}, "R6");
                2: do_write(2'd3, {2'b11, 2'($urandom), 3'($urandom), 1'b0}, "R8");
                3, 4, 5: do_write(ch, 8'($urandom), "R3");
                6, 7, 8: do_read(ch, "R7");
                default: do_read(2'd3, "R11");
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule